// File: doc/BRIEF.md
# Configurable external reset controller

This block turns a general-purpose input pin into a device-wide reset for a small programmable logic fabric. A two-bit mode field picks how the pin acts. It can be ignored, it can act as a level reset that holds the device while the pin is high, or it can act as an edge reset that fires on a rising or a falling transition, as chosen by a polarity bit. The pin is brought into the clock domain by a two-flop synchronizer before any detection.

After a trigger the block pulses or holds its reset output, which clears internal logic, routing and pad state. It then runs a restart sequence, a down-counter of `SEQ_LEN` cycles. While that sequence runs, the global output-enable gate keeps every pad in high impedance. The gate opens in the same cycle that the done flag rises. The power-on reset input overrides everything. The retain flag stays high whenever the power-on reset is low, so an external reset never reloads or clears the stored non-volatile configuration. The mode and polarity are captured only while the block is idle, which is the state where the sequence is done and no reset is active.

Top module: `ext_rst_ctrl`

## Requirements
- R1: With the captured mode at 2'b00 or 2'b11 (disabled), no activity on the pin ever raises `sys_rst`.
- R2: With the captured mode at 2'b01 (level), `sys_rst` is high one cycle after the synchronized pin is high. This is the third rising edge at which the pin is sampled high. `sys_rst` stays high for as long as the pin stays high.
- R3: In level mode, the high-to-low transition of the pin ends the reset. `seq_done` then rises `SEQ_LEN` cycles after the last cycle in which `sys_rst` was high.
- R4: With the captured mode at 2'b10 (edge), `cfg_rise`=1 selects rising edges and `cfg_rise`=0 selects falling edges. A matching synchronized edge gives a one-cycle `sys_rst` pulse and starts the sequence. A transition of the other direction has no effect.
- R5: A trigger that arrives while a sequence is running reloads the counter to its full value. `seq_done` therefore rises exactly `SEQ_LEN` cycles after the most recent cycle in which `sys_rst` was high.
- R6: `nvm_keep` is high whenever `por` is low, including during and after any external reset.
- R7: `oe_en` is low whenever `seq_done` is low or `sys_rst` is high, and it opens in the same cycle that `seq_done` rises.
- R8: While `por` is high, the outputs are held at `sys_rst`=1, `seq_done`=0, `oe_en`=0 and `nvm_keep`=0, whatever the configuration and the pin. `por` also returns the captured mode to disabled.
- R9: `cfg_mode` and `cfg_rise` are captured only at clock edges where `seq_done` is high. A change made while a sequence runs has no effect until the sequence completes.
- R10: After `por` falls, `seq_done` and `oe_en` rise after exactly `SEQ_LEN` clock edges. The counter decrements by one on each edge that has no trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por | input | 1 | Power-on reset, active high, asynchronous |
| pin_in | input | 1 | Raw pin level, synchronized inside the block |
| cfg_mode | input | 2 | 00 disabled, 01 level, 10 edge, 11 disabled |
| cfg_rise | input | 1 | Edge polarity: 1 rising, 0 falling |
| sys_rst | output | 1 | Reset to internal logic, routing and I/O |
| seq_done | output | 1 | Restart sequence complete |
| oe_en | output | 1 | Global pad output-enable gate, 1 lets outputs drive |
| nvm_keep | output | 1 | Retain flag that keeps non-volatile configuration |

## Verification
The pin is driven through the disabled encodings with free toggling, which tells apart a correctly ignored pin from a leaking trigger. In level mode a multi-cycle high pulse separates a held reset from a single pulse. In edge mode the pin gets transitions of both directions under each polarity, so a wrong polarity decode shows up as a missing or extra pulse. A second edge that lands mid-sequence, together with a configuration change made at the same time, distinguishes a counter reload from a continued count and a latched mode from a live one. Power-on reset is also raised in the middle of a sequence to show its priority.

// File: rtl/ext_rst_ctrl.sv
module ext_rst_ctrl #(
  parameter int SEQ_LEN = 16,
  localparam int CW = $clog2(SEQ_LEN + 1)
) (
  input  logic       clk,
  input  logic       por,
  input  logic       pin_in,
  input  logic [1:0] cfg_mode,
  input  logic       cfg_rise,
  output logic       sys_rst,
  output logic       seq_done,
  output logic       oe_en,
  output logic       nvm_keep
);
  localparam logic [1:0]    M_LEVEL = 2'b01;
  localparam logic [1:0]    M_EDGE  = 2'b10;
  localparam logic [CW-1:0] FULL    = CW'(SEQ_LEN);

  // shr[0] first sync stage, shr[1] synchronized level, shr[2] previous level
  logic [2:0]    shr;
  logic [1:0]    mode_q;
  logic          rise_q;
  logic          rst_q;
  logic [CW-1:0] cnt;

  wire pin_s    = shr[1];
  wire pin_p    = shr[2];
  wire idle     = (cnt == '0);
  wire lvl_hit  = (mode_q == M_LEVEL) && pin_s;
  wire edge_hit = (mode_q == M_EDGE) &&
                  (rise_q ? (pin_s && !pin_p) : (!pin_s && pin_p));
  wire trig     = lvl_hit || edge_hit;

  always_ff @(posedge clk or posedge por) begin
    if (por) begin
      shr    <= '0;
      mode_q <= '0;
      rise_q <= 1'b0;
      rst_q  <= 1'b0;
      cnt    <= FULL;
    end else begin
      shr   <= {shr[1:0], pin_in};
      rst_q <= trig;
      if (trig)
        cnt <= FULL;
      else if (!idle)
        cnt <= cnt - 1'b1;
      if (idle) begin
        mode_q <= cfg_mode;
        rise_q <= cfg_rise;
      end
    end
  end

  assign sys_rst  = por | rst_q;
  assign seq_done = ~por & idle;
  assign oe_en    = seq_done;
  assign nvm_keep = ~por;
endmodule

// File: rtl/ext_rst_ctrl_chk.sv
module ext_rst_ctrl_chk #(
  parameter int CW = 5
) (
  input logic          clk,
  input logic          por,
  input logic          sys_rst,
  input logic          seq_done,
  input logic          oe_en,
  input logic          nvm_keep,
  input logic [1:0]    mode_q,
  input logic          trig,
  input logic [CW-1:0] cnt
);
  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (por)
    ((mode_q == 2'b00 || mode_q == 2'b11) && seq_done) |=> !sys_rst); // R1

  AST_DONE_FALL_BY_RST: assert property (@(posedge clk) disable iff (por)
    $fell(seq_done) |-> sys_rst); // R3

  AST_RETRIG_RELOAD: assert property (@(posedge clk) disable iff (por)
    trig |=> (sys_rst && !seq_done)); // R5

  AST_KEEP_NVM: assert property (@(posedge clk) disable iff (por)
    nvm_keep); // R6

  AST_RST_NO_OE: assert property (@(posedge clk) disable iff (por)
    sys_rst |-> !oe_en); // R7

  AST_POR_HOLD: assert property (@(posedge clk)
    por |-> (sys_rst && !oe_en && !seq_done && !nvm_keep)); // R8

  AST_CFG_LATCHED: assert property (@(posedge clk) disable iff (por)
    !seq_done |=> $stable(mode_q)); // R9

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (por)
    (cnt != '0 && !trig) |=> (cnt == $past(cnt) - 1'b1)); // R10
endmodule

bind ext_rst_ctrl ext_rst_ctrl_chk #(.CW(CW)) u_chk (
  .clk(clk), .por(por), .sys_rst(sys_rst), .seq_done(seq_done),
  .oe_en(oe_en), .nvm_keep(nvm_keep), .mode_q(mode_q), .trig(trig), .cnt(cnt)
);

// File: tb/ext_rst_ctrl_test.sv
`timescale 1ns/1ps
module ext_rst_ctrl_test;
  localparam int N = 16;

  logic clk = 1'b0;
  logic por = 1'b1;
  logic pin_in = 1'b0;
  logic [1:0] cfg_mode = 2'b00;
  logic cfg_rise = 1'b0;
  logic sys_rst, seq_done, oe_en, nvm_keep;

  int checks = 0;
  int failures = 0;
  bit finished = 0;
  bit quiet_phase = 0;

  always #2.5 clk = ~clk;

  ext_rst_ctrl #(.SEQ_LEN(N)) uut (
    .clk(clk), .por(por), .pin_in(pin_in), .cfg_mode(cfg_mode), .cfg_rise(cfg_rise),
    .sys_rst(sys_rst), .seq_done(seq_done), .oe_en(oe_en), .nvm_keep(nvm_keep)
  );

  // behavioural reference
  int remain = N;
  bit m_rst = 0;
  int m_mode = 0;
  bit m_rise = 0;
  bit pinq[$] = '{0, 0, 0};

  always @(posedge clk or posedge por) begin
    if (por) begin
      remain = N; m_rst = 0; m_mode = 0; m_rise = 0; pinq = '{0, 0, 0};
    end else begin
      bit now_v, old_v, hit, was_idle;
      now_v = pinq[1];
      old_v = pinq[2];
      hit = (m_mode == 1 && now_v) ||
            (m_mode == 2 && (m_rise ? (now_v && !old_v) : (!now_v && old_v)));
      was_idle = (remain == 0);
      if (hit) remain = N;
      else if (remain > 0) remain = remain - 1;
      m_rst = hit;
      if (was_idle) begin m_mode = int'(cfg_mode); m_rise = cfg_rise; end
      pinq.push_front(pin_in);
      void'(pinq.pop_back());
    end
  end

  task automatic check(string req, logic act, logic exp, string what);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%b expected=%b t=%0t", req, what, act, exp, $time);
    end
  endtask

  int since_rst = 0;
  bit prev_done = 0;

  always begin
    @(posedge clk);
    #1;
    if (!finished) begin
      bit e_rst, e_done;
      string rtag;
      e_rst  = por || m_rst;
      e_done = !por && remain == 0;
      if (por) rtag = "R8";
      else if (m_mode == 1) rtag = "R2";
      else if (m_mode == 2) rtag = "R4";
      else rtag = "R1";
      check(rtag, sys_rst, e_rst, "sys_rst");
      check(por ? "R8" : "R10", seq_done, e_done, "seq_done");
      check("R7", oe_en, e_done, "oe_en");
      check(por ? "R8" : "R6", nvm_keep, !por, "nvm_keep");
      if (quiet_phase) check("R9", sys_rst, 1'b0, "late cfg sys_rst");
      if (sys_rst) since_rst = 0; else since_rst++;
      if (seq_done && !prev_done) check("R5", 1'b1, 1'(since_rst == N), "seq length");
      if (seq_done && !prev_done && m_mode == 0 && since_rst != N)
        $display("  R3 sequence length %0d", since_rst);
      prev_done = seq_done;
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    cyc(4);
    por = 1'b0;
    cyc(20);
    for (int i = 0; i < 10; i++) begin pin_in = ~pin_in; cyc(1 + i % 3); end
    cfg_mode = 2'b11; cyc(3);
    for (int i = 0; i < 10; i++) begin pin_in = ~pin_in; cyc(2); end
    pin_in = 1'b0;
    // R2 / R3 level mode
    cfg_mode = 2'b01; cyc(3);
    pin_in = 1'b1; cyc(6);
    pin_in = 1'b0; cyc(22);
    // R4 rising edge, then R5 retrigger with R9 mid-sequence change
    cfg_mode = 2'b10; cfg_rise = 1'b1; cyc(3);
    pin_in = 1'b1; cyc(3);
    pin_in = 1'b0; cyc(8);
    cfg_mode = 2'b00;
    pin_in = 1'b1; cyc(3);
    pin_in = 1'b0; cyc(24);
    quiet_phase = 1;
    for (int i = 0; i < 8; i++) begin pin_in = ~pin_in; cyc(2); end
    quiet_phase = 0;
    pin_in = 1'b0;
    // R4 falling edge
    cfg_mode = 2'b10; cfg_rise = 1'b0; cyc(3);
    pin_in = 1'b1; cyc(5);
    pin_in = 1'b0; cyc(22);
    // R8 por mid-sequence
    pin_in = 1'b1; cyc(4);
    pin_in = 1'b0; cyc(6);
    por = 1'b1; cyc(3);
    por = 1'b0; cyc(22);
    pin_in = 1'b1; cyc(4);
    pin_in = 1'b0; cyc(4);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      finished = 1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule